// File: doc/BRIEF.md
# Oversampled Serial Phase Tracker

This block recovers the data bits of a serial line that is sampled blindly in the local clock domain. Each bit period is covered by five samples at evenly spaced phases. The samples arrive as parallel words of `OSR*NBITS` samples, earliest sample in bit 0. The sampling clocks get no feedback. Instead the block looks for transitions between neighbouring samples and bins each one by its phase slot. It keeps these counts over a window of words and reads the bit boundary from the busiest slot. It then takes the sample phase that lies furthest from that boundary.

Each window produces one candidate phase. A vote over the most recent candidates decides whether the working phase moves. Two voting modes exist: all candidates must agree, or a strict majority suffices. When local and remote rates differ, the boundary creeps around the five slots. Each time the working phase wraps across the word edge, the block emits one bit fewer or one bit more in that cycle. A count output tells the consumer how many of the output bits are valid, so no elastic buffer is needed.

Top module: `oversample_phase_tracker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `rx_count` and `rx_bits` are zero. The working phase after reset is slot 2 (`OSR/2`).
- R2: A cycle with `in_valid` low gives `rx_count` 0 and `rx_bits` 0 one cycle later, whatever `in_word` holds.
- R3: For a valid word with no pending wrap, the next cycle gives `rx_count` = NBITS. `rx_bits[k]` equals `in_word[sel + OSR*k]`, with `rx_bits[0]` the earliest bit. Bits at and above `rx_count` are zero.
- R4: A transition between sample i-1 and sample i of the stream counts in slot (i-1) mod OSR. Sample 0 is compared with the last sample of the previous valid word. Counts cover WIN_WORDS valid words. The busiest slot (lowest index on a tie) is the boundary, and the candidate phase is boundary+3 mod 5.
- R5: With `cfg_majority` = 0, the phase moves only when the last VOTES window candidates are all equal and differ from the current phase. The new phase applies to valid words accepted from the third cycle after a window closes.
- R6: With `cfg_majority` = 1, the phase moves to any candidate held by more than half of the last VOTES windows. Before VOTES windows have completed, the phase does not move.
- R7: A phase move to a lower slot by more than OSR/2 (4 to 0) makes the next valid word give NBITS-1 bits. These are the picks for k = 1..NBITS-1.
- R8: A phase move to a higher slot by more than OSR/2 (0 to 4) makes the next valid word give NBITS+1 bits. `rx_bits[0]` is the last sample of the previous valid word, followed by the NBITS picks.
- R9: For a stream whose bit period drifts by one sample every few hundred bits, in either direction, the concatenated output bits equal the transmitted bits.
- R10: After a valid word, `rx_count` lies between NBITS-1 and NBITS+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_majority | input | 1 | 0: all votes must agree; 1: strict majority |
| in_valid | input | 1 | `in_word` holds a new sample word |
| in_word | input | OSR*NBITS | Oversampled samples, bit 0 earliest |
| rx_bits | output | NBITS+1 | Recovered bits, bit 0 earliest |
| rx_count | output | $clog2(NBITS+2) | Number of valid bits in `rx_bits` |

## Verification
The bench uses OSR 5, NBITS 8, WIN_WORDS 12 and VOTES 3. A window is therefore 96 bit periods, within the averaging range the block is meant for. A phase move then needs only three windows, so a few dozen words are enough to watch a vote hold or fire. The working phase is read at the ports by probe words that carry ones only in a single slot. The drift streams shift by one sample every 600 bits. Over 6000 bits this walks the phase through several wraps in both directions, which exercises both the shortened word and the lengthened word.

// File: rtl/opt_pkg.sv
`timescale 1ns/1ps
// Shared types of the oversampled phase tracker.
// Assumes the oversampling ratio never exceeds 8, so a phase fits in PHASE_W bits.
package opt_pkg;
    localparam int PHASE_W = 3;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic {
        VOTE_UNANIMOUS = 1'b0,
        VOTE_MAJORITY  = 1'b1
    } vote_mode_e;

    typedef struct packed {
        phase_t sel;    // working sample phase
        logic   drop;   // next valid word emits one bit fewer
        logic   extra;  // next valid word emits one bit more
    } phase_state_t;
endpackage

// File: rtl/opt_edge_hist.sv
`timescale 1ns/1ps
// Edge histogram: bins every transition between neighbouring samples by phase slot,
// accumulates over WIN_WORDS valid words and, one cycle after a window closes,
// presents the candidate sample phase (furthest slot from the busiest boundary).
// Assumes WIN_WORDS >= 2 and OSR <= 8.
module opt_edge_hist
    import opt_pkg::*;
#(
    parameter int OSR       = 5,
    parameter int NBITS     = 8,
    parameter int WIN_WORDS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OSR*NBITS-1:0] in_word,
    output logic                 last_sample,
    output phase_t               cand,
    output logic                 cand_valid
);
    localparam int W   = OSR * NBITS;
    localparam int CW  = $clog2(WIN_WORDS * NBITS + 1);
    localparam int WCW = $clog2(WIN_WORDS);
    localparam logic [WCW-1:0] WIN_LAST = WCW'(WIN_WORDS - 1);

    logic [W:0]     ext;
    logic [W-1:0]   flips;
    logic [CW-1:0]  word_hits [OSR];
    logic [CW-1:0]  acc [OSR];
    logic [WCW-1:0] win_cnt;
    logic           done_q;
    phase_t         best;
    logic [CW-1:0]  best_val;

    assign ext   = {in_word, last_sample};
    assign flips = ext[W:1] ^ ext[W-1:0];

    // Count this word's transitions per phase slot.
    always_comb begin
        for (int s = 0; s < OSR; s++) word_hits[s] = '0;
        for (int i = 0; i < W; i++)
            word_hits[(i + OSR - 1) % OSR] = word_hits[(i + OSR - 1) % OSR] + CW'(flips[i]);
    end

    // Keep the last sample of the previous valid word for the carry edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_sample <= 1'b0;
        else if (in_valid) last_sample <= in_word[W-1];
    end

    // Track the position inside the window and flag its close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= in_valid && (win_cnt == WIN_LAST);
            if (in_valid) win_cnt <= (win_cnt == WIN_LAST) ? '0 : win_cnt + 1'b1;
        end
    end

    // Accumulate slot counts; restart them the cycle after the window closes.
    always_ff @(posedge clk) begin
        for (int s = 0; s < OSR; s++) begin
            if (!rst_n)        acc[s] <= '0;
            else if (done_q)   acc[s] <= in_valid ? word_hits[s] : '0;
            else if (in_valid) acc[s] <= acc[s] + word_hits[s];
        end
    end

    // Pick the busiest slot, lowest index on a tie.
    always_comb begin
        best     = '0;
        best_val = acc[0];
        for (int s = 1; s < OSR; s++) begin
            if (acc[s] > best_val) begin
                best_val = acc[s];
                best     = phase_t'(s);
            end
        end
    end

    assign cand       = phase_t'((int'(best) + OSR / 2 + 1) % OSR);
    assign cand_valid = done_q;
endmodule

// File: rtl/opt_phase_vote.sv
`timescale 1ns/1ps
// Phase vote: keeps the last VOTES window candidates, moves the working phase when
// the selected voting rule agrees, and marks wraps across the word edge as a pending
// drop or extra bit for the next valid word.
// Assumes candidates are always below OSR.
module opt_phase_vote
    import opt_pkg::*;
#(
    parameter int OSR   = 5,
    parameter int VOTES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_t       cand,
    input  logic         cand_valid,
    input  vote_mode_e   mode,
    input  logic         word_taken,
    output phase_state_t st
);
    localparam int FW = $clog2(VOTES + 1);
    localparam logic [FW-1:0] FULL = FW'(VOTES);

    phase_t        hist [VOTES];
    logic [FW-1:0] fill;
    logic          vote_q;
    logic [FW-1:0] hits [VOTES];
    logic          agree;
    phase_t        target;
    logic          move, drop_new, extra_new, drop_keep, extra_keep;
    phase_t        sel_q;
    logic          pend_drop, pend_extra;

    // Shift in each new candidate and count how many windows are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < VOTES; j++) hist[j] <= '0;
            fill   <= '0;
            vote_q <= 1'b0;
        end else begin
            vote_q <= cand_valid;
            if (cand_valid) begin
                hist[0] <= cand;
                for (int j = 1; j < VOTES; j++) hist[j] <= hist[j-1];
                if (fill != FULL) fill <= fill + 1'b1;
            end
        end
    end

    // Count for each held candidate how many entries share its value.
    always_comb begin
        for (int j = 0; j < VOTES; j++) begin
            hits[j] = '0;
            for (int k = 0; k < VOTES; k++)
                hits[j] = hits[j] + FW'(hist[k] == hist[j]);
        end
    end

    // Apply the voting rule of the selected mode.
    always_comb begin
        agree  = 1'b0;
        target = hist[0];
        if (mode == VOTE_UNANIMOUS) begin
            agree = (hits[0] == FULL);
        end else begin
            for (int j = VOTES - 1; j >= 0; j--) begin
                if (int'(hits[j]) > VOTES / 2) begin
                    agree  = 1'b1;
                    target = hist[j];
                end
            end
        end
    end

    assign move       = vote_q && (fill == FULL) && agree && (target != sel_q);
    assign drop_new   = (sel_q > target) && (int'(sel_q) - int'(target) > OSR / 2);
    assign extra_new  = (target > sel_q) && (int'(target) - int'(sel_q) > OSR / 2);
    assign drop_keep  = pend_drop & ~word_taken;
    assign extra_keep = pend_extra & ~word_taken;

    // Update the working phase and the pending bit-count adjustment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= phase_t'(OSR / 2);
            pend_drop  <= 1'b0;
            pend_extra <= 1'b0;
        end else if (move) begin
            sel_q      <= target;
            pend_drop  <= (drop_keep & ~extra_new) | (drop_new & ~extra_keep);
            pend_extra <= (extra_keep & ~drop_new) | (extra_new & ~drop_keep);
        end else begin
            pend_drop  <= drop_keep;
            pend_extra <= extra_keep;
        end
    end

    assign st = '{sel: sel_q, drop: pend_drop, extra: pend_extra};
endmodule

// File: rtl/opt_bit_picker.sv
`timescale 1ns/1ps
// Bit picker: takes the sample at the working phase from every bit period of a valid
// word and registers NBITS-1, NBITS or NBITS+1 bits as the phase state demands.
// Assumes last_sample still holds the previous valid word's final sample.
module opt_bit_picker
    import opt_pkg::*;
#(
    parameter int OSR   = 5,
    parameter int NBITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [OSR*NBITS-1:0]        in_word,
    input  logic                        last_sample,
    input  phase_state_t                st,
    output logic [NBITS:0]              rx_bits,
    output logic [$clog2(NBITS+2)-1:0]  rx_count
);
    localparam int CNTW = $clog2(NBITS + 2);

    logic [NBITS-1:0] picks;

    for (genvar k = 0; k < NBITS; k++) begin : g_pick
        logic [OSR-1:0] grp;
        assign grp      = in_word[OSR*k +: OSR];
        assign picks[k] = grp[st.sel];
    end

    // Register the recovered bits and how many of them are valid.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            rx_bits  <= '0;
            rx_count <= '0;
        end else if (st.extra) begin
            rx_bits  <= {picks, last_sample};
            rx_count <= CNTW'(NBITS + 1);
        end else if (st.drop) begin
            rx_bits  <= {2'b00, picks[NBITS-1:1]};
            rx_count <= CNTW'(NBITS - 1);
        end else begin
            rx_bits  <= {1'b0, picks};
            rx_count <= CNTW'(NBITS);
        end
    end
endmodule

// File: rtl/oversample_phase_tracker.sv
`timescale 1ns/1ps
// Oversampled phase tracker top: edge histogram, phase vote and bit picker in a row.
// Assumes in_word is blindly sampled at OSR evenly spaced phases per bit period.
module oversample_phase_tracker
    import opt_pkg::*;
#(
    parameter int OSR       = 5,
    parameter int NBITS     = 8,
    parameter int WIN_WORDS = 12,
    parameter int VOTES     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_majority,
    input  logic                        in_valid,
    input  logic [OSR*NBITS-1:0]        in_word,
    output logic [NBITS:0]              rx_bits,
    output logic [$clog2(NBITS+2)-1:0]  rx_count
);
    logic         last_sample;
    phase_t       cand;
    logic         cand_valid;
    phase_state_t st;

    opt_edge_hist #(.OSR(OSR), .NBITS(NBITS), .WIN_WORDS(WIN_WORDS)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .last_sample (last_sample),
        .cand        (cand),
        .cand_valid  (cand_valid)
    );

    opt_phase_vote #(.OSR(OSR), .VOTES(VOTES)) u_vote (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand       (cand),
        .cand_valid (cand_valid),
        .mode       (vote_mode_e'(cfg_majority)),
        .word_taken (in_valid),
        .st         (st)
    );

    opt_bit_picker #(.OSR(OSR), .NBITS(NBITS)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .last_sample (last_sample),
        .st          (st),
        .rx_bits     (rx_bits),
        .rx_count    (rx_count)
    );
endmodule

// File: rtl/opt_checker.sv
`timescale 1ns/1ps
// Property checker for the oversampled phase tracker, attached by bind.
// Assumes the reset is held for at least two clock edges.
module opt_checker
    import opt_pkg::*;
#(
    parameter int OSR   = 5,
    parameter int NBITS = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [NBITS:0]              rx_bits,
    input logic [$clog2(NBITS+2)-1:0]  rx_count,
    input phase_t                      sel,
    input logic                        cand_valid
);
    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (rx_count == 0 && rx_bits == 0));

    // R10
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (rx_count >= NBITS - 1 && rx_count <= NBITS + 1));

    // R3
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bits >> rx_count) == '0);

    // R5
    sel_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> $past(cand_valid, 2));

    // R4
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel) < OSR);
endmodule

bind oversample_phase_tracker opt_checker #(.OSR(OSR), .NBITS(NBITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .rx_bits    (rx_bits),
    .rx_count   (rx_count),
    .sel        (st.sel),
    .cand_valid (cand_valid)
);

// File: tb/oversample_phase_tracker_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module oversample_phase_tracker_test;
    localparam int OSR = 5, NBITS = 8, WIN = 12, VOTES = 3;
    localparam int W = OSR * NBITS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_majority = 1'b0;
    logic             in_valid = 1'b0;
    logic [W-1:0]     in_word = '0;
    logic [NBITS:0]   rx_bits;
    logic [3:0]       rx_count;

    int checks = 0;
    int errors = 0;
    bit samp_q[$];
    bit tx_q[$];
    bit out_q[$];
    bit collect = 1'b0;
    bit saw_drop, saw_extra, bad_count;

    localparam logic [NBITS:0] ALL_ONES = {1'b0, {NBITS{1'b1}}};

    oversample_phase_tracker #(.OSR(OSR), .NBITS(NBITS), .WIN_WORDS(WIN), .VOTES(VOTES)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_majority (cfg_majority),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .rx_bits      (rx_bits),
        .rx_count     (rx_count)
    );

    always #10 clk = ~clk;

    // Gather recovered bits between edges while a stream test runs.
    always @(negedge clk) begin
        if (collect && rx_count != 0) begin
            for (int k = 0; k < int'(rx_count); k++) out_q.push_back(rx_bits[k]);
            if (rx_count == NBITS - 1) saw_drop = 1'b1;
            if (rx_count == NBITS + 1) saw_extra = 1'b1;
            if (rx_count < NBITS - 1 || rx_count > NBITS + 1) bad_count = 1'b1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit maj);
        rst_n = 1'b0;
        in_valid = 1'b0;
        cfg_majority = maj;
        samp_q.delete(); tx_q.delete(); out_q.delete();
        collect = 1'b0; saw_drop = 1'b0; saw_extra = 1'b0; bad_count = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive_word(input logic [W-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push_bit(input bit b, input int len);
        repeat (len) samp_q.push_back(b);
        tx_q.push_back(b);
    endtask

    task automatic push_random(input int offset, input int nsamp);
        bit b0 = 1'($urandom);
        repeat (offset) samp_q.push_back(b0);
        while (samp_q.size() < nsamp) push_bit(1'($urandom), OSR);
    endtask

    task automatic feed_words(input int n);
        for (int j = 0; j < n; j++) begin
            logic [W-1:0] w;
            for (int i = 0; i < W; i++) w[i] = samp_q.pop_front();
            drive_word(w);
        end
    endtask

    // Feed a word with ones only in one slot; all-ones output means that slot is in use.
    task automatic probe(input int slot, input string req);
        logic [W-1:0] w = '0;
        for (int k = 0; k < NBITS; k++) w[slot + OSR*k] = 1'b1;
        drive_word(w);
        check(req, rx_bits, ALL_ONES);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        check("R1 count after reset", rx_count, 0);
        check("R1 bits after reset", rx_bits, 0);
    endtask

    task automatic t_pick_and_idle;
        logic [W-1:0]     w;
        logic [NBITS:0]   exp;
        do_reset(1'b0);
        w   = {$urandom, $urandom};
        exp = '0;
        for (int k = 0; k < NBITS; k++) exp[k] = w[2 + OSR*k];
        drive_word(w);
        check("R3 picks at slot 2", rx_bits, exp);
        check("R3 count", rx_count, NBITS);
        in_word = '1;
        @(negedge clk);
        check("R2 idle count", rx_count, 0);
        check("R2 idle bits", rx_bits, 0);
    endtask

    // Static offset: two windows must not move the phase, the third must.
    task automatic t_static(input int offset, input int slot_exp, input string req);
        do_reset(1'b0);
        push_random(offset, 4 * WIN * W);
        feed_words(2 * WIN);
        repeat (3) @(negedge clk);
        probe(2, "R5 phase held after two windows");
        feed_words(WIN - 1);
        repeat (3) @(negedge clk);
        probe(slot_exp, req);
    endtask

    // Windows alternate between two boundaries; the vote rule decides the outcome.
    task automatic t_vote(input bit maj, input int slot_exp, input string req);
        do_reset(maj);
        for (int win = 0; win < 4; win++) begin
            samp_q.delete();
            push_random((win % 2 == 1) ? 4 : 0, WIN * W);
            feed_words(WIN);
        end
        repeat (3) @(negedge clk);
        probe(slot_exp, req);
    endtask

    // Drifting stream: every 600th bit lasts odd_len samples.
    task automatic t_drift(input int odd_len, input string req_wrap);
        int n, mism;
        do_reset(1'b0);
        collect = 1'b1;
        for (int j = 0; j < 6000; j++) push_bit(1'($urandom), (j % 600 == 599) ? odd_len : OSR);
        feed_words(samp_q.size() / W);
        repeat (3) @(negedge clk);
        collect = 1'b0;
        n = ((out_q.size() < tx_q.size()) ? out_q.size() : tx_q.size()) - 4;
        mism = 0;
        for (int i = 0; i < n; i++) if (out_q[i] != tx_q[i]) mism++;
        check("R9 stream mismatches", mism, 0);
        check("R9 stream length", n > 5800, 1);
        check(req_wrap, (odd_len > OSR) ? saw_drop : saw_extra, 1);
        check("R10 count range", bad_count, 0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pick_and_idle();
        t_static(2, 4, "R4 R5 offset 2 moves to slot 4");
        t_static(3, 0, "R4 offset 3 moves to slot 0");
        t_static(1, 3, "R4 offset 1 moves to slot 3");
        t_vote(1'b0, 2, "R5 unanimous holds on split windows");
        t_vote(1'b1, 1, "R6 majority follows two of three");
        t_drift(6, "R7 short word seen on 4 to 0 wrap");
        t_drift(4, "R8 long word seen on 0 to 4 wrap");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule